// File: doc/BRIEF.md
# Bus Software Watchdog with Interrupt Escalation

This block is a software watchdog for a bus-based system controller. A free-running counter advances once per bus clock while the watchdog is enabled. When it reaches the selected timeout, the block raises an interrupt request. Software keeps the watchdog quiet by writing a two-byte key sequence to a service location: 0x55 followed by 0xAA. A completed sequence restarts the count. The timeout is chosen by a prescale bit and a two-bit select. A changed selection is latched only by the next completed key sequence.

During the interrupt-acknowledge strobe, the block drives a programmable 8-bit vector. If the request is still unacknowledged after one more full timeout and escalation is enabled, the block pulses a transfer acknowledge for one cycle, so that a stalled bus cycle can complete. It also sets a sticky status flag that software clears by writing 1 to it.

Registers are reached through a synchronous write port with a combinational read. Address 0 is control and status, address 1 is the service key location (write-only), and address 2 is the vector (write-only).

Top module: `swd_watchdog`

## Requirements
- R1: After reset, control reads 0x80 (enabled, prescale 0, select 00, escalation off, flag clear), the vector is 0x0F, and the first request appears 512 clocks after reset is released.
- R2: The timeout is 2^(9+2*sel) clocks with prescale 0 and 2^(22+2*sel) clocks with prescale 1. The request rises on the clock edge that ends that many clocks after the last restart.
- R3: Writing 0x55 and then 0xAA on consecutive service writes restarts the count from zero at the 0xAA write.
- R4: A new prescale/select written to control takes effect only at the next completed key sequence. Until then the previously latched timeout stays in force.
- R5: A service write that is not 0xAA, when it directly follows 0x55, cancels the sequence. A 0xAA that does not follow 0x55 is ignored. Every 0x55 arms the sequence again.
- R6: The interrupt request stays high from timeout until an acknowledge strobe arrives while it is pending. That strobe clears the request and restarts the count.
- R7: With escalation enabled (control bit 3), a request still pending one more full timeout after it rose produces a single-cycle transfer-acknowledge pulse. With escalation disabled, no pulse occurs.
- R8: Control bit 2 reads 1 from the cycle after a transfer-acknowledge pulse. Writing 1 to bit 2 clears it, and writing 0 leaves it set.
- R9: While the enable bit (control bit 7) is 0, the count holds its value. When the bit is set again, counting resumes from that value.
- R10: Control bits 1:0 read as 0 whatever is written to them. Reads of the service and vector locations return 0.
- R11: The vector written to address 2 appears on the vector output while the acknowledge strobe is high. The output is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 control, 1 service, 2 vector |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| iack | input | 1 | Interrupt-acknowledge strobe |
| iack_vec | output | 8 | Vector driven during acknowledge, else 0 |
| irq | output | 1 | Watchdog interrupt request |
| xfer_ack | output | 1 | Single-cycle forced transfer acknowledge |

## Verification
The hardest situation to reach from the ports is the escalation pulse. It needs an interrupt left unserviced for a second full timeout with escalation enabled, and it must land on one exact clock edge. The bench counts clock edges from the completing 0xAA write and samples the pulse in the cycle before it, the cycle of it and the cycle after it. Key-sequence corner cases are reached by random bursts of service writes (0x55, 0xAA or arbitrary bytes) placed late in a 512-clock window. A restart then shows up as a missing timeout that a bench model of the sequence predicts.

// File: rtl/swd_pkg.sv
package swd_pkg;

   typedef enum logic [1:0] {
      RA_CTRL = 2'd0,
      RA_SVC  = 2'd1,
      RA_VEC  = 2'd2,
      RA_NONE = 2'd3
   } swd_addr_e;

   // control byte layout
   localparam int B_EN     = 7;
   localparam int B_PRE    = 6;
   localparam int B_SEL_HI = 5;
   localparam int B_SEL_LO = 4;
   localparam int B_XEN    = 3;
   localparam int B_FLAG   = 2;

   typedef struct packed {
      logic       en;
      logic       pre;
      logic [1:0] sel;
      logic       xen;
   } swd_ctrl_t;

endpackage

// File: rtl/swd_regs.sv
module swd_regs
   import swd_pkg::*;
#(
   parameter int         DW      = 8,
   parameter logic [7:0] VEC_RST = 8'h0F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   input  logic          svc_done,
   input  logic          xack_set,
   output swd_ctrl_t     ctl,
   output logic [2:0]    act_code,
   output logic [DW-1:0] vec,
   output logic          flag,
   output logic [DW-1:0] rdata
);

   logic wr_ctl, wr_vec;
   logic unused_rsvd;

   assign wr_ctl      = wr_en && (addr == RA_CTRL);
   assign wr_vec      = wr_en && (addr == RA_VEC);
   assign unused_rsvd = ^wdata[1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl      <= '{en: 1'b1, pre: 1'b0, sel: 2'b00, xen: 1'b0};
         act_code <= 3'b000;
         vec      <= VEC_RST;
         flag     <= 1'b0;
      end else begin
         if (wr_ctl)
            ctl <= '{en:  wdata[B_EN],
                     pre: wdata[B_PRE],
                     sel: wdata[B_SEL_HI:B_SEL_LO],
                     xen: wdata[B_XEN]};
         if (wr_vec)
            vec <= wdata;
         if (svc_done)
            act_code <= {ctl.pre, ctl.sel};
         if (xack_set)
            flag <= 1'b1;
         else if (wr_ctl && wdata[B_FLAG])
            flag <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == RA_CTRL)
         rdata = {ctl.en, ctl.pre, ctl.sel, ctl.xen, flag, 2'b00};
   end

endmodule

// File: rtl/swd_svc.sv
module swd_svc
   import swd_pkg::*;
#(
   parameter int            DW   = 8,
   parameter logic [DW-1:0] KEY1 = 8'h55,
   parameter logic [DW-1:0] KEY2 = 8'hAA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic          svc_done
);

   logic armed;
   logic wr_svc;

   assign wr_svc   = wr_en && (addr == RA_SVC);
   assign svc_done = wr_svc && armed && (wdata == KEY2);

   always_ff @(posedge clk) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (wr_svc)
         armed <= (wdata == KEY1);
   end

endmodule

// File: rtl/swd_timer.sv
module swd_timer #(
   parameter int CNT_W    = 28,
   parameter int LO_EXP   = 9,
   parameter int HI_EXP   = 22,
   parameter int EXP_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             xen,
   input  logic [2:0]       code,
   input  logic             svc_done,
   input  logic             iack,
   output logic             irq,
   output logic             xfer_ack,
   output logic [CNT_W-1:0] cnt
);

   localparam int NCODE   = 8;
   localparam int MAX_EXP = HI_EXP + 3 * EXP_STEP;

   if (MAX_EXP > CNT_W) begin : g_bad_width
      $error("swd_timer: CNT_W too small for the longest timeout");
   end
   if (LO_EXP < 1 || LO_EXP + 3 * EXP_STEP > HI_EXP) begin : g_bad_exp
      $error("swd_timer: timeout exponents out of order");
   end

   logic [CNT_W-1:0] mask_tab [0:NCODE-1];

   for (genvar g = 0; g < NCODE; g++) begin : g_mask
      localparam int E = ((g >= 4) ? HI_EXP : LO_EXP) + EXP_STEP * (g % 4);
      assign mask_tab[g] = {CNT_W{1'b1}} >> (CNT_W - E);
   end

   logic restart, term;

   assign restart = svc_done || (iack && irq);
   assign term    = en && (cnt == mask_tab[code]) && !restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         irq      <= 1'b0;
         xfer_ack <= 1'b0;
      end else begin
         xfer_ack <= 1'b0;
         if (restart || term)
            cnt <= '0;
         else if (en)
            cnt <= cnt + CNT_W'(1);
         if (iack && irq)
            irq <= 1'b0;
         else if (term) begin
            if (!irq)
               irq <= 1'b1;
            else if (xen)
               xfer_ack <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/swd_watchdog.sv
module swd_watchdog
   import swd_pkg::*;
#(
   parameter int         CNT_W    = 28,
   parameter int         LO_EXP   = 9,
   parameter int         HI_EXP   = 22,
   parameter int         EXP_STEP = 2,
   parameter logic [7:0] VEC_RST  = 8'h0F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   input  logic       iack,
   output logic [7:0] iack_vec,
   output logic       irq,
   output logic       xfer_ack
);

   localparam int DW = 8;

   swd_ctrl_t        ctl;
   logic [2:0]       act_code;
   logic [DW-1:0]    vec;
   logic             flag_q;
   logic             svc_done;
   logic             ctl_en;
   logic [CNT_W-1:0] cnt;

   assign ctl_en = ctl.en;

   swd_regs #(.DW(DW), .VEC_RST(VEC_RST)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .svc_done (svc_done),
      .xack_set (xfer_ack),
      .ctl      (ctl),
      .act_code (act_code),
      .vec      (vec),
      .flag     (flag_q),
      .rdata    (rdata)
   );

   swd_svc #(.DW(DW)) u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .svc_done (svc_done)
   );

   swd_timer #(
      .CNT_W    (CNT_W),
      .LO_EXP   (LO_EXP),
      .HI_EXP   (HI_EXP),
      .EXP_STEP (EXP_STEP)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctl_en),
      .xen      (ctl.xen),
      .code     (act_code),
      .svc_done (svc_done),
      .iack     (iack),
      .irq      (irq),
      .xfer_ack (xfer_ack),
      .cnt      (cnt)
   );

   assign iack_vec = iack ? vec : '0;

endmodule

// File: rtl/swd_chk.sv
module swd_chk #(
   parameter int CNT_W = 28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iack,
   input logic             irq,
   input logic             xfer_ack,
   input logic [7:0]       iack_vec,
   input logic [1:0]       rsvd,
   input logic             flag,
   input logic             en,
   input logic             svc_done,
   input logic [CNT_W-1:0] cnt
);

   AST_XACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |=> !xfer_ack); // R7

   AST_XACK_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |-> irq); // R7

   AST_FLAG_AFTER_XACK: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ack |=> flag); // R8

   AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(xfer_ack)); // R8

   AST_IACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && iack) |=> !irq); // R6

   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !iack) |=> irq); // R6

   AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !iack |-> (iack_vec == 8'h00)); // R11

   AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !svc_done && !(iack && irq)) |=> $stable(cnt)); // R9

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd == 2'b00); // R10

endmodule

bind swd_watchdog swd_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .iack     (iack),
   .irq      (irq),
   .xfer_ack (xfer_ack),
   .iack_vec (iack_vec),
   .rsvd     (rdata[1:0]),
   .flag     (flag_q),
   .en       (ctl_en),
   .svc_done (svc_done),
   .cnt      (cnt)
);

// File: tb/tb_swd_watchdog.sv
`timescale 1ns/1ps
module tb_swd_watchdog;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       iack = 1'b0;
   logic [7:0] iack_vec;
   logic       irq;
   logic       xfer_ack;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   int unsigned xcnt = 0;
   logic [7:0]  cur_vec = 8'h0F;

   always #2 clk = ~clk;

   swd_watchdog dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .iack(iack), .iack_vec(iack_vec), .irq(irq), .xfer_ack(xfer_ack)
   );

   always @(negedge clk) if (rst_n && xfer_ack) xcnt++;

   function automatic int unsigned period_of(input bit pre, input int sel);
      return 32'd1 << ((pre ? 22 : 9) + 2 * sel);
   endfunction

   function automatic logic [7:0] ctl_byte(input bit en, input bit pre,
                                            input int sel, input bit xen, input bit clr);
      return {en, pre, sel[1:0], xen, clr, 2'b00};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; addr = 2'd0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
      addr = 2'd0;
   endtask

   task automatic service();
      wr(2'd1, 8'h55);
      wr(2'd1, 8'hAA);
   endtask

   task automatic ack(input string req);
      iack = 1'b1;
      #1;
      check(req, iack_vec, cur_vec);
      @(negedge clk);
      iack = 1'b0;
      #0.5;
      check(req, iack_vec, 8'h00);
      check(req, irq, 1'b0);
   endtask

   task automatic measure(input int unsigned p, input string req);
      service();
      waitn(p - 1);
      check(req, irq, 1'b0);
      waitn(1);
      check(req, irq, 1'b1);
      ack(req);
   endtask

   // run a burst of service writes late in a 512-clock window
   task automatic run_seq(input logic [7:0] s[6], input int n, input string req);
      bit armed = 1'b0;
      bit done = 1'b0;
      service();
      waitn(300);
      for (int i = 0; i < n; i++) begin
         wr(2'd1, s[i]);
         if (s[i] == 8'h55) armed = 1'b1;
         else if (s[i] == 8'hAA && armed) begin done = 1'b1; armed = 1'b0; end
         else armed = 1'b0;
      end
      waitn(220 - n);
      check(req, irq, done ? 1'b0 : 1'b1);
      if (irq) ack("R11");
   endtask

   initial begin
      logic [7:0] d;
      logic [7:0] s[6];
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'd4242);
      waitn(3);
      rst_n = 1'b1;
      #0.5;
      // reset state
      rd(2'd0, d); check("R1", d, 8'h80);
      rd(2'd1, d); check("R10", d, 8'h00);
      rd(2'd2, d); check("R10", d, 8'h00);
      check("R1", irq, 1'b0);
      check("R11", iack_vec, 8'h00);
      check("R7", xfer_ack, 1'b0);
      @(negedge clk);
      // first timeout from reset (one edge consumed above)
      waitn(510);
      check("R1", irq, 1'b0);
      waitn(1);
      check("R1", irq, 1'b1);
      waitn(20);
      check("R6", irq, 1'b1);
      ack("R6");
      // reserved bits
      wr(2'd0, 8'hFF);
      rd(2'd0, d); check("R10", d, 8'hF8);
      wr(2'd0, 8'h80);
      // R4: new select written after service is not yet in force
      service();
      wr(2'd0, ctl_byte(1, 0, 1, 0, 0));
      waitn(510);
      check("R4", irq, 1'b0);
      waitn(1);
      check("R4", irq, 1'b1);
      ack("R4");
      // R2/R3 timeout table, prescale 0
      for (int c = 0; c < 4; c++) begin
         wr(2'd0, ctl_byte(1, 0, c, 0, 0));
         measure(period_of(0, c), "R2");
      end
      // prescale 1: far longer than any low period
      wr(2'd0, ctl_byte(1, 1, 0, 0, 0));
      service();
      waitn(33000);
      check("R2", irq, 1'b0);
      wr(2'd0, 8'h80);
      service();
      // R9 enable stops count
      waitn(200);
      wr(2'd0, 8'h00);
      waitn(1000);
      check("R9", irq, 1'b0);
      wr(2'd0, 8'h80);
      waitn(305);
      check("R9", irq, 1'b0);
      waitn(10);
      check("R9", irq, 1'b1);
      ack("R9");
      // R7/R8 escalation
      wr(2'd0, ctl_byte(1, 0, 0, 1, 0));
      service();
      waitn(512);
      check("R7", irq, 1'b1);
      waitn(511);
      check("R7", xfer_ack, 1'b0);
      waitn(1);
      check("R7", xfer_ack, 1'b1);
      waitn(1);
      check("R7", xfer_ack, 1'b0);
      rd(2'd0, d); check("R8", d, 8'h8C);
      wr(2'd0, ctl_byte(1, 0, 0, 1, 0));
      rd(2'd0, d); check("R8", d, 8'h8C);
      wr(2'd0, ctl_byte(1, 0, 0, 1, 1));
      rd(2'd0, d); check("R8", d, 8'h88);
      check("R7", irq, 1'b1);
      ack("R6");
      // escalation disabled
      wr(2'd0, 8'h80);
      xcnt = 0;
      service();
      waitn(1100);
      check("R7", irq, 1'b1);
      check("R7", xcnt, 0);
      ack("R6");
      // R11 programmed vector
      cur_vec = 8'hA5;
      wr(2'd2, cur_vec);
      // directed R5 cases
      s = '{8'h55, 8'h12, 8'hAA, 8'h00, 8'h00, 8'h00};
      run_seq(s, 3, "R5");
      s = '{8'hAA, 8'h00, 8'hAA, 8'h00, 8'h00, 8'h00};
      run_seq(s, 3, "R5");
      s = '{8'h55, 8'h55, 8'hAA, 8'h00, 8'h00, 8'h00};
      run_seq(s, 3, "R5");
      s = '{8'h55, 8'hAA, 8'h00, 8'h00, 8'h00, 8'h00};
      run_seq(s, 2, "R3");
      // random bursts
      for (int it = 0; it < 20; it++) begin
         int n;
         cur_vec = 8'($urandom);
         wr(2'd2, cur_vec);
         n = 1 + int'($urandom % 6);
         for (int k = 0; k < 6; k++) begin
            case ($urandom % 3)
               0: s[k] = 8'h55;
               1: s[k] = 8'hAA;
               default: s[k] = 8'($urandom);
            endcase
         end
         run_seq(s, n, "R5");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule